// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates between a set of level-sensitive device request lines and one CPU interrupt input. Each line has a fixed priority: line 0 is the most urgent. An edge-triggered non-maskable input ranks above all of them. When the most urgent pending request outranks the priority now in service, the block raises an interrupt to the CPU. On the CPU acknowledge, it acknowledges the chosen device and waits for that device to return a handler vector. It passes the vector to the CPU with a one-cycle strobe. If no vector arrives within a fixed number of cycles, it pulses a bus-error flag instead.

Accepted services are nested on an internal priority stack. A delivered vector pushes the level of the service it starts. An end-of-service strobe pops the top level, which restores the priority of the interrupted service. While a service is running, any device request at the same or a lower level stays pending. The non-maskable source is taken on its rising edge, whatever priority is in service. It uses a fixed vector and no device handshake.

Top module: `prio_vec_intc`

## Requirements
- R1: While waiting for a vector, `dev_ack` is one-hot on the selected line, and it is all zero at every other time. `dev_ack` is never high together with `cpu_irq`. A non-maskable service never drives `dev_ack`.
- R2: A device request whose level is not above `cur_prio` raises no `cpu_irq` and stays pending. It is taken once end-of-service lowers `cur_prio` below its level.
- R3: Device line i has level N_SRC-i. Among simultaneous requests, the lowest-numbered line wins. An eligible request present before clock edge k makes `cpu_irq` high after edge k.
- R4: A `vec_valid` sampled while waiting makes `vec_out` equal `vec_in` and pulses `vec_stb` for one cycle, both after that same edge. `vec_stb` and `bus_err` are never high together.
- R5: A delivered vector pushes the service level, and `cur_prio` shows that level after the delivery edge. Each `eos` pops one level. An `eos` on an empty stack is ignored. `cur_prio` is 0 when nothing is in service. If a push and a pop happen in the same cycle, the new level replaces the top entry.
- R6: A rising edge on `nmi` raises `cpu_irq` after the second following clock edge, even while the highest device level is in service. A held-high `nmi` does not retrigger. On `cpu_ack`, the block emits `NMI_VEC` with `vec_stb`, and `cur_prio` becomes N_SRC+1.
- R7: `cpu_irq` drops after the edge at which `cpu_ack` is sampled high.
- R8: If no `vec_valid` arrives, `bus_err` pulses after the TIMEOUT-th edge spent waiting. At that edge `dev_ack` is released and nothing is pushed.
- R9: After reset, `cpu_irq`, `dev_ack`, `vec_stb`, `bus_err` and `cur_prio` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_SRC | Level-sensitive device requests; bit 0 is the most urgent |
| nmi | input | 1 | Non-maskable request, taken on its rising edge |
| cpu_ack | input | 1 | CPU acknowledge of `cpu_irq` |
| vec_valid | input | 1 | The acknowledged device presents its vector |
| vec_in | input | VEC_W | Vector returned by the device |
| eos | input | 1 | End-of-service strobe from the CPU |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| dev_ack | output | N_SRC | One-hot acknowledge to the selected device |
| vec_out | output | VEC_W | Last delivered handler vector |
| vec_stb | output | 1 | One-cycle pulse marking a new `vec_out` |
| bus_err | output | 1 | One-cycle pulse when the vector wait times out |
| cur_prio | output | PRIO_W | Priority level now in service (0 when idle) |

## Verification
A device request raises `cpu_irq` one edge after it is applied. The NMI takes two edges, because its edge detector adds one register. `dev_ack` appears one edge after `cpu_ack`. `vec_out`, `vec_stb` and the new `cur_prio` appear one edge after `vec_valid`. A pop shows on `cur_prio` one edge after `eos`, but arbitration uses the old level for that cycle, so a waiting request is taken one edge later still. `bus_err` appears exactly TIMEOUT edges after `dev_ack` first shows. The bench drives every input on the falling edge and checks at the next falling edge. It checks at the exact cycle each result is due, and also at the cycles just before, where the output must still be quiet.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_VWAIT = 2'd2
  } intc_state_e;

  // Priority level of device line idx in a controller with n lines.
  function automatic int unsigned line_level(input int unsigned idx,
                                             input int unsigned n);
    return n - idx;
  endfunction

  // Level reserved for the non-maskable source.
  function automatic int unsigned nmi_level(input int unsigned n);
    return n + 1;
  endfunction

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [N_SRC-1:0]  req,
  input  logic              nmi_pend,
  output logic              any,
  output logic              is_nmi,
  output logic [PRIO_W-1:0] win_lvl,
  output logic [IDX_W-1:0]  win_idx
);

  always_comb begin
    any     = 1'b0;
    is_nmi  = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    // scan from the least urgent line so the lowest index overwrites last
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = PRIO_W'(line_level(int'(i), N_SRC));
      end
    end
    if (nmi_pend) begin
      any     = 1'b1;
      is_nmi  = 1'b1;
      win_idx = '0;
      win_lvl = PRIO_W'(nmi_level(N_SRC));
    end
  end

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int DEPTH = 6,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full
);

  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic            empty;
  logic            pop_evt;

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign pop_evt = pop && !empty;
  assign top     = empty ? '0 : mem[IX_W'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && pop_evt) begin
      mem[IX_W'(sp - 1'b1)] <= din;
    end else if (push && !full) begin
      mem[IX_W'(sp)] <= din;
      sp             <= sp + 1'b1;
    end else if (pop_evt) begin
      sp <= sp - 1'b1;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop_evt));

endmodule

// File: rtl/intc_ack_timer.sv
module intc_ack_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (start)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int          N_SRC   = 4,
  parameter int          VEC_W   = 8,
  parameter int          TIMEOUT = 16,
  parameter logic [7:0]  NMI_VEC = 8'hFE
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_SRC-1:0]                    dev_req,
  input  logic                                nmi,
  input  logic                                cpu_ack,
  input  logic                                vec_valid,
  input  logic [VEC_W-1:0]                    vec_in,
  input  logic                                eos,
  output logic                                cpu_irq,
  output logic [N_SRC-1:0]                    dev_ack,
  output logic [VEC_W-1:0]                    vec_out,
  output logic                                vec_stb,
  output logic                                bus_err,
  output logic [$clog2(N_SRC+2)-1:0]          cur_prio
);

  localparam int PRIO_W = $clog2(N_SRC + 2);
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int DEPTH  = N_SRC + 2;

  intc_state_e       state;
  logic              nmi_q, nmi_pend, nmi_rise;
  logic              any, is_nmi, full;
  logic [PRIO_W-1:0] win_lvl, sel_lvl;
  logic [IDX_W-1:0]  win_idx, sel_idx;
  logic              sel_nmi;
  logic              accept_evt, push_evt, expired;

  intc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .req(dev_req), .nmi_pend(nmi_pend), .any(any), .is_nmi(is_nmi),
    .win_lvl(win_lvl), .win_idx(win_idx)
  );

  intc_prio_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .pop(eos), .din(sel_lvl),
    .top(cur_prio), .full(full)
  );

  intc_ack_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(state == ST_REQ),
    .run(state == ST_VWAIT), .expired(expired)
  );

  assign nmi_rise   = nmi && !nmi_q;
  assign accept_evt = (state == ST_IDLE) && any && !full &&
                      (is_nmi || (win_lvl > cur_prio));
  assign push_evt   = ((state == ST_REQ) && cpu_ack && sel_nmi) ||
                      ((state == ST_VWAIT) && vec_valid);
  assign cpu_irq    = (state == ST_REQ);
  assign dev_ack    = (state == ST_VWAIT) ? (N_SRC'(1) << sel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi;
      nmi_pend <= (nmi_pend && !(accept_evt && is_nmi)) || nmi_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sel_nmi <= 1'b0;
      sel_idx <= '0;
      sel_lvl <= '0;
      vec_out <= '0;
      vec_stb <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      vec_stb <= 1'b0;
      bus_err <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_evt) begin
          state   <= ST_REQ;
          sel_nmi <= is_nmi;
          sel_idx <= win_idx;
          sel_lvl <= win_lvl;
        end
        ST_REQ: if (cpu_ack) begin
          if (sel_nmi) begin
            state   <= ST_IDLE;
            vec_out <= VEC_W'(NMI_VEC);
            vec_stb <= 1'b1;
          end else begin
            state <= ST_VWAIT;
          end
        end
        ST_VWAIT: begin
          if (vec_valid) begin
            state   <= ST_IDLE;
            vec_out <= vec_in;
            vec_stb <= 1'b1;
          end else if (expired) begin
            state   <= ST_IDLE;
            bus_err <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));
  // R1
  irq_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_irq && (|dev_ack)));
  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack) |=> !cpu_irq);
  // R8
  err_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(|dev_ack));
  // R4
  err_stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && vec_stb));
  // R5
  push_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !eos) |=> (cur_prio >= $past(cur_prio)) && (cur_prio != '0));

endmodule

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;

  localparam int N       = 4;
  localparam int VW      = 8;
  localparam int TMO     = 16;
  localparam logic [7:0] NMIV = 8'hFE;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  dev_req;
  logic          nmi, cpu_ack, vec_valid, eos;
  logic [VW-1:0] vec_in;
  logic          cpu_irq, vec_stb, bus_err;
  logic [N-1:0]  dev_ack;
  logic [VW-1:0] vec_out;
  logic [2:0]    cur_prio;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  prio_vec_intc #(.N_SRC(N), .VEC_W(VW), .TIMEOUT(TMO), .NMI_VEC(NMIV)) uut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi(nmi), .cpu_ack(cpu_ack),
    .vec_valid(vec_valid), .vec_in(vec_in), .eos(eos), .cpu_irq(cpu_irq),
    .dev_ack(dev_ack), .vec_out(vec_out), .vec_stb(vec_stb), .bus_err(bus_err),
    .cur_prio(cur_prio)
  );

  // entry: {request mask[13:10], returned vector[9:2], expected winner[1:0]}
  localparam logic [13:0] TBL [7] = '{
    {4'b0001, 8'h10, 2'd0},
    {4'b0010, 8'h21, 2'd1},
    {4'b1000, 8'h43, 2'd3},
    {4'b1100, 8'h52, 2'd2},
    {4'b0110, 8'h66, 2'd1},
    {4'b1111, 8'h7A, 2'd0},
    {4'b1010, 8'h8B, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // run one full device service from request to delivered vector
  task automatic serve(input logic [N-1:0] req, input logic [VW-1:0] v, input int idx);
    dev_req = req;
    step();
    chk("R3 irq after request", cpu_irq, 1);
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    chk("R7 irq dropped", cpu_irq, 0);
    chk("R1 ack to winner", dev_ack, N'(1) << idx);
    vec_valid = 1'b1;
    vec_in    = v;
    step();
    vec_valid = 1'b0;
    chk("R4 strobe", vec_stb, 1);
    chk("R4 vector", vec_out, v);
    chk("R5 pushed level", cur_prio, N - idx);
    chk("R1 ack released", dev_ack, 0);
  endtask

  task automatic pop_once();
    eos = 1'b1;
    step();
    eos = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dev_req = '0; nmi = 1'b0; cpu_ack = 1'b0;
    vec_valid = 1'b0; vec_in = '0; eos = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9 irq", cpu_irq, 0);
    chk("R9 ack", dev_ack, 0);
    chk("R9 stb", vec_stb, 0);
    chk("R9 err", bus_err, 0);
    chk("R9 prio", cur_prio, 0);

    // R5 pop on empty stack is ignored
    pop_once();
    chk("R5 empty pop", cur_prio, 0);

    // table walk: arbitration and single-level service
    for (int k = 0; k < 7; k++) begin
      serve(TBL[k][13:10], TBL[k][9:2], int'(TBL[k][1:0]));
      dev_req = '0;
      pop_once();
      chk("R5 popped to idle", cur_prio, 0);
      step();
    end

    // R2 masking of equal and lower levels, then nesting
    serve(4'b0010, 8'h31, 1);
    dev_req = 4'b0110;
    for (int c = 0; c < 4; c++) begin
      step();
      chk("R2 masked no irq", cpu_irq, 0);
    end
    serve(4'b0111, 8'h32, 0);
    dev_req = 4'b0110;
    pop_once();
    chk("R5 nested pop", cur_prio, 3);
    chk("R2 still masked", cpu_irq, 0);
    pop_once();
    chk("R5 stack empty", cur_prio, 0);
    chk("R2 irq not yet", cpu_irq, 0);
    step();
    chk("R2 pending taken", cpu_irq, 1);

    // R8 vector timeout on line 1
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    chk("R1 ack line1", dev_ack, 4'b0010);
    for (int c = 0; c < TMO - 1; c++) begin
      step();
      chk("R8 no early error", bus_err, 0);
    end
    dev_req = '0;
    step();
    chk("R8 bus error", bus_err, 1);
    chk("R8 ack released", dev_ack, 0);
    chk("R8 nothing pushed", cur_prio, 0);
    chk("R4 no strobe on error", vec_stb, 0);
    step();

    // R6 NMI over the highest device level
    serve(4'b0001, 8'h44, 0);
    nmi = 1'b1;
    step();
    chk("R6 nmi one edge", cpu_irq, 0);
    step();
    chk("R6 nmi irq", cpu_irq, 1);
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    chk("R1 no ack for nmi", dev_ack, 0);
    chk("R6 nmi strobe", vec_stb, 1);
    chk("R6 nmi vector", vec_out, NMIV);
    chk("R6 nmi level", cur_prio, N + 1);
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R6 held nmi no retrigger", cpu_irq, 0);
    end
    nmi = 1'b0;
    pop_once();
    chk("R5 back to line0", cur_prio, N);
    dev_req = '0;
    pop_once();
    chk("R5 idle after nmi", cur_prio, 0);
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule